// File: doc/BRIEF.md
# Masked Bus Watchpoint Comparator with Chained Halt

This block sits beside a processor's bus and watches every transfer. It holds two independent comparison units. Each unit has a value and a mask for the address bus, the data bus and a small set of bus control signals. A unit also has an access-kind setting: it either watches data accesses or instruction fetches. When an enabled unit sees a valid transfer whose unmasked bits all equal its programmed pattern, the block raises a one-cycle halt request to the core. It also records which unit caused the halt in a sticky status register.

The two units can be chained. In chain mode a match on unit 0 only arms the block. A halt then needs a later match on unit 1. The registers are loaded through a dedicated one-cycle write port, which is kept apart from the core's bus.

The bus side is a pure monitor. It has `bus_valid` but no ready signal, so the block never applies back-pressure. Every cycle with `bus_valid` high is one transfer, and it is judged once, in that cycle. The register port has no handshake either: each pulse of `wr_en` is accepted in its own cycle.

Top module: `dbg_watch_top`

## Requirements
- R1: After reset, every register is zero, `halt_req` is low, `stat_hit` is 0 and `chain_armed` is low.
- R2: When `wr_en` is high at a clock edge, the register selected by `wr_idx` takes `wr_data` at that edge. The register map is:
  - Index 3u+0: unit u address. Value in bits [15:0], mask in bits [31:16].
  - Index 3u+1: unit u data. Same layout as the address register.
  - Index 3u+2: unit u configuration. Bit 0 is the kind (1 = instruction fetch, 0 = data access), bits [2:1] are the control value, bits [4:3] are the control mask.
  - Index 6: control. Bit 0 enables unit 0, bit 1 enables unit 1, bit 2 selects chain mode.
  - Index 7: status clear. Writing 1 to a bit clears that status bit.
- R3: A unit matches only when address, data and `bus_ctl` all equal its programmed values on every bit whose mask bit is 0. A mask bit of 1 removes that bit from the comparison.
- R4: A cycle with `bus_valid` low never matches. The clock edge that follows such a cycle never raises `halt_req`.
- R5: A unit whose kind bit is 1 matches only transfers with `bus_fetch` = 1. A unit whose kind bit is 0 matches only transfers with `bus_fetch` = 0.
- R6: A unit whose enable bit is 0 never causes a halt and never sets its status bit.
- R7: `halt_req` goes high in the cycle after the matching transfer. It stays high for one cycle only, unless the next transfer also matches.
- R8: `stat_hit[i]` becomes 1 when unit i causes a halt. It stays 1 until a write of 1 to bit i at index 7. If a new hit and a clear land on the same edge, the new hit wins.
- R9: In chain mode, a unit 0 match sets `chain_armed` and never halts. Unit 1 halts only if `chain_armed` was already set before its transfer. A transfer that matches both units while the block is not armed only arms it.
- R10: `chain_armed` clears on the edge where the chained halt is taken. It is also held clear while chain mode is off.
- R11: Matching transfers on consecutive cycles give `halt_req` high on consecutive cycles. No transfer is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 3 | Register index |
| wr_data | input | 32 | Register write data |
| bus_valid | input | 1 | Bus carries a transfer this cycle |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_addr | input | AW (16) | Bus address |
| bus_data | input | DW (16) | Bus data |
| bus_ctl | input | CW (2) | Bus control signals to compare |
| halt_req | output | 1 | Registered halt request to the core |
| stat_hit | output | 2 | Sticky record of which unit caused a halt |
| chain_armed | output | 1 | Unit 0 condition met while in chain mode |

## Verification
The properties assume that every input is at a known level once reset is released. They also assume inputs change only between rising edges, so a transfer and a register write seen at the same edge belong to the same cycle. The bench drives everything from fixed values on the falling edge and samples on the following falling edge, so each check sees exactly one registered step. When the bench puts a register write and a bus transfer in the same cycle, it does so on purpose, to test the rule that a new hit beats a clear on the same edge.

// File: rtl/dbg_watch_pkg.sv
package dbg_watch_pkg;
  localparam int NUM_UNITS = 2;
  localparam int REG_W     = 32;
  localparam int HALF_W    = 16;

  typedef enum logic [2:0] {
    RI_U0_ADDR = 3'd0,
    RI_U0_DATA = 3'd1,
    RI_U0_CFG  = 3'd2,
    RI_U1_ADDR = 3'd3,
    RI_U1_DATA = 3'd4,
    RI_U1_CFG  = 3'd5,
    RI_CTRL    = 3'd6,
    RI_STAT    = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/dbg_watch_regs.sv
module dbg_watch_regs
  import dbg_watch_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [2:0]                       wr_idx,
  input  logic [REG_W-1:0]                 wr_data,
  output logic [NUM_UNITS-1:0][AW-1:0]     a_val,
  output logic [NUM_UNITS-1:0][AW-1:0]     a_msk,
  output logic [NUM_UNITS-1:0][DW-1:0]     d_val,
  output logic [NUM_UNITS-1:0][DW-1:0]     d_msk,
  output logic [NUM_UNITS-1:0]             kind,
  output logic [NUM_UNITS-1:0][CW-1:0]     c_val,
  output logic [NUM_UNITS-1:0][CW-1:0]     c_msk,
  output logic [NUM_UNITS-1:0]             unit_en,
  output logic                             chain_en,
  output logic [NUM_UNITS-1:0]             stat_clr
);
  localparam int CFG_KIND  = 0;
  localparam int CFG_CVAL  = 1;
  localparam int CFG_CMSK  = CFG_CVAL + CW;
  localparam int CTRL_CHN  = NUM_UNITS;

  // per-unit register groups, three indices each
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    localparam logic [2:0] BASE = 3'(u * 3);
    logic [AW-1:0] av, am;
    logic [DW-1:0] dv, dm;
    logic          kd;
    logic [CW-1:0] cv, cm;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        av <= '0; am <= '0; dv <= '0; dm <= '0;
        kd <= 1'b0; cv <= '0; cm <= '0;
      end else if (wr_en) begin
        if (wr_idx == BASE) begin
          av <= wr_data[AW-1:0];
          am <= wr_data[HALF_W +: AW];
        end
        if (wr_idx == BASE + 3'd1) begin
          dv <= wr_data[DW-1:0];
          dm <= wr_data[HALF_W +: DW];
        end
        if (wr_idx == BASE + 3'd2) begin
          kd <= wr_data[CFG_KIND];
          cv <= wr_data[CFG_CVAL +: CW];
          cm <= wr_data[CFG_CMSK +: CW];
        end
      end
    end

    assign a_val[u] = av;
    assign a_msk[u] = am;
    assign d_val[u] = dv;
    assign d_msk[u] = dm;
    assign kind[u]  = kd;
    assign c_val[u] = cv;
    assign c_msk[u] = cm;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unit_en  <= '0;
      chain_en <= 1'b0;
    end else if (wr_en && wr_idx == RI_CTRL) begin
      unit_en  <= wr_data[NUM_UNITS-1:0];
      chain_en <= wr_data[CTRL_CHN];
    end
  end

  assign stat_clr = (wr_en && wr_idx == RI_STAT) ? wr_data[NUM_UNITS-1:0] : '0;

  // R2: a control write is visible on the next cycle
  p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == RI_CTRL) |=> (chain_en == $past(wr_data[CTRL_CHN])));
endmodule

// File: rtl/dbg_watch_cmp.sv
module dbg_watch_cmp #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 2
) (
  input  logic          bus_valid,
  input  logic          bus_fetch,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic [CW-1:0] bus_ctl,
  input  logic [AW-1:0] a_val,
  input  logic [AW-1:0] a_msk,
  input  logic [DW-1:0] d_val,
  input  logic [DW-1:0] d_msk,
  input  logic          kind,
  input  logic [CW-1:0] c_val,
  input  logic [CW-1:0] c_msk,
  input  logic          en,
  output logic          hit
);
  logic a_ok, d_ok, c_ok, k_ok;

  // a mask bit of 1 drops that bit from the comparison
  assign a_ok = ((bus_addr ^ a_val) & ~a_msk) == '0;
  assign d_ok = ((bus_data ^ d_val) & ~d_msk) == '0;
  assign c_ok = ((bus_ctl  ^ c_val) & ~c_msk) == '0;
  assign k_ok = (bus_fetch == kind);

  assign hit = en & bus_valid & k_ok & a_ok & d_ok & c_ok;
endmodule

// File: rtl/dbg_watch_halt.sv
module dbg_watch_halt
  import dbg_watch_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_UNITS-1:0] hit,
  input  logic                 chain_en,
  input  logic [NUM_UNITS-1:0] stat_clr,
  output logic                 halt_req,
  output logic [NUM_UNITS-1:0] stat_hit,
  output logic                 chain_armed
);
  logic [NUM_UNITS-1:0] fire;
  logic                 armed_d;

  // in chain mode unit 0 only arms; unit 1 needs an earlier arm
  assign fire[0] = hit[0] & ~chain_en;
  assign fire[1] = hit[1] & (~chain_en | chain_armed);

  always_comb begin
    if (!chain_en)    armed_d = 1'b0;
    else if (fire[1]) armed_d = 1'b0;
    else if (hit[0])  armed_d = 1'b1;
    else              armed_d = chain_armed;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt_req    <= 1'b0;
      stat_hit    <= '0;
      chain_armed <= 1'b0;
    end else begin
      halt_req    <= |fire;
      stat_hit    <= (stat_hit & ~stat_clr) | fire;
      chain_armed <= armed_d;
    end
  end

  p_halt_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> (stat_hit != '0));

  p_chain_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && $past(chain_en)) |-> $past(chain_armed));

  p_chain_u0_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(chain_en) && !$past(stat_hit[0])) |-> !stat_hit[0]);

  p_arm_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !chain_en |=> !chain_armed);

  p_arm_taken_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && $past(chain_en)) |-> !chain_armed);
endmodule

// File: rtl/dbg_watch_top.sv
module dbg_watch_top
  import dbg_watch_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [2:0]           wr_idx,
  input  logic [REG_W-1:0]     wr_data,
  input  logic                 bus_valid,
  input  logic                 bus_fetch,
  input  logic [AW-1:0]        bus_addr,
  input  logic [DW-1:0]        bus_data,
  input  logic [CW-1:0]        bus_ctl,
  output logic                 halt_req,
  output logic [NUM_UNITS-1:0] stat_hit,
  output logic                 chain_armed
);
  logic [NUM_UNITS-1:0][AW-1:0] a_val, a_msk;
  logic [NUM_UNITS-1:0][DW-1:0] d_val, d_msk;
  logic [NUM_UNITS-1:0]         kind, unit_en, stat_clr, hit;
  logic [NUM_UNITS-1:0][CW-1:0] c_val, c_msk;
  logic                         chain_en;

  dbg_watch_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .a_val(a_val), .a_msk(a_msk), .d_val(d_val), .d_msk(d_msk), .kind(kind),
    .c_val(c_val), .c_msk(c_msk), .unit_en(unit_en), .chain_en(chain_en),
    .stat_clr(stat_clr)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_cmp
    dbg_watch_cmp #(.AW(AW), .DW(DW), .CW(CW)) u_cmp (
      .bus_valid(bus_valid), .bus_fetch(bus_fetch), .bus_addr(bus_addr),
      .bus_data(bus_data), .bus_ctl(bus_ctl),
      .a_val(a_val[u]), .a_msk(a_msk[u]), .d_val(d_val[u]), .d_msk(d_msk[u]),
      .kind(kind[u]), .c_val(c_val[u]), .c_msk(c_msk[u]), .en(unit_en[u]),
      .hit(hit[u])
    );
  end

  dbg_watch_halt u_halt (
    .clk(clk), .rst_n(rst_n), .hit(hit), .chain_en(chain_en),
    .stat_clr(stat_clr), .halt_req(halt_req), .stat_hit(stat_hit),
    .chain_armed(chain_armed)
  );

  // R4: an idle bus cycle is never followed by a halt
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> !halt_req);
endmodule

// File: tb/dbg_watch_top_test.sv
module dbg_watch_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        bus_valid = 1'b0;
  logic        bus_fetch = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [15:0] bus_data = '0;
  logic [1:0]  bus_ctl = '0;
  logic        halt_req;
  logic [1:0]  stat_hit;
  logic        chain_armed;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_watch_top uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .bus_valid(bus_valid), .bus_fetch(bus_fetch), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_ctl(bus_ctl), .halt_req(halt_req),
    .stat_hit(stat_hit), .chain_armed(chain_armed)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] i, input logic [31:0] d);
    wr_en = 1'b1; wr_idx = i; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic xfer(input logic v, input logic f, input logic [1:0] c,
                      input logic [15:0] a, input logic [15:0] d);
    bus_valid = v; bus_fetch = f; bus_ctl = c; bus_addr = a; bus_data = d;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 halt", halt_req, 0);
    chk("R1 stat", stat_hit, 0);
    chk("R1 armed", chain_armed, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // unit 0: addr 1234, data BEEF, data access, ctl value 01, ctl mask 00
    wr(3'd0, 32'h0000_1234);
    wr(3'd1, 32'h0000_BEEF);
    wr(3'd2, 32'h0000_0002);
    wr(3'd6, 32'h1);

    // R2 R3: every address bit, unmasked then masked
    for (int b = 0; b < 16; b++) begin
      xfer(1, 0, 2'b01, 16'h1234 ^ 16'(1 << b), 16'hBEEF);
      chk("R3 addr bit unmasked", halt_req, 0);
      wr(3'd0, (32'(1 << b) << 16) | 32'h1234);
      xfer(1, 0, 2'b01, 16'h1234 ^ 16'(1 << b), 16'hBEEF);
      chk("R3 addr bit masked R2", halt_req, 1);
      chk("R8 stat unit0", stat_hit, 2'b01);
      wr(3'd7, 32'h3);
      wr(3'd0, 32'h0000_1234);
    end
    for (int b = 0; b < 16; b++) begin
      xfer(1, 0, 2'b01, 16'h1234, 16'hBEEF ^ 16'(1 << b));
      chk("R3 data bit unmasked", halt_req, 0);
      wr(3'd1, (32'(1 << b) << 16) | 32'hBEEF);
      xfer(1, 0, 2'b01, 16'h1234, 16'hBEEF ^ 16'(1 << b));
      chk("R3 data bit masked R2", halt_req, 1);
      wr(3'd7, 32'h3);
      wr(3'd1, 32'h0000_BEEF);
    end

    // R3 R4 R5: kind x ctl mask x valid x fetch x ctl
    for (int k = 0; k < 2; k++) begin
      for (int cm = 0; cm < 4; cm++) begin
        wr(3'd2, 32'((cm << 3) | (1 << 1) | k));
        for (int v = 0; v < 2; v++) begin
          for (int f = 0; f < 2; f++) begin
            for (int c = 0; c < 4; c++) begin
              xfer(v[0], f[0], c[1:0], 16'h1234, 16'hBEEF);
              chk("R4 R5 R3 sweep", halt_req,
                  32'((v == 1) && (f == k) && ((((c ^ 1) & ~cm) & 3) == 0)));
              wr(3'd7, 32'h3);
            end
          end
        end
      end
    end

    // R6: disabled unit
    wr(3'd2, 32'h2);
    wr(3'd6, 32'h0);
    xfer(1, 0, 2'b01, 16'h1234, 16'hBEEF);
    chk("R6 disabled halt", halt_req, 0);
    chk("R6 disabled stat", stat_hit, 0);

    // R7: single-cycle pulse; R8 sticky
    wr(3'd6, 32'h1);
    xfer(1, 0, 2'b01, 16'h1234, 16'hBEEF);
    chk("R7 halt pulse", halt_req, 1);
    xfer(0, 0, 2'b01, 16'h1234, 16'hBEEF);
    chk("R7 halt drops", halt_req, 0);
    chk("R8 sticky", stat_hit, 2'b01);
    wr(3'd7, 32'h1);
    chk("R8 cleared", stat_hit, 0);

    // unit 1: addr 4000 exact, data any, ctl any, data access
    wr(3'd3, 32'h0000_4000);
    wr(3'd4, 32'hFFFF_0000);
    wr(3'd5, 32'h0000_0018);
    wr(3'd6, 32'h3);
    xfer(1, 0, 2'b00, 16'h4000, 16'h5555);
    chk("R8 unit1 halt", halt_req, 1);
    chk("R8 unit1 stat", stat_hit, 2'b10);
    wr(3'd7, 32'h1);
    chk("R8 clear other bit", stat_hit, 2'b10);
    wr(3'd7, 32'h2);
    chk("R8 clear own bit", stat_hit, 0);
    // new hit and clear on the same edge
    wr_en = 1'b1; wr_idx = 3'd7; wr_data = 32'h2;
    xfer(1, 0, 2'b11, 16'h4000, 16'h0);
    wr_en = 1'b0;
    chk("R8 set wins", stat_hit, 2'b10);
    wr(3'd7, 32'h3);

    // R11: back-to-back transfers
    bus_valid = 1'b1; bus_fetch = 1'b0; bus_addr = 16'h4000; bus_data = 16'h1;
    @(negedge clk);
    chk("R11 first", halt_req, 1);
    @(negedge clk);
    chk("R11 second", halt_req, 1);
    bus_valid = 1'b0;
    @(negedge clk);
    chk("R11 idle", halt_req, 0);
    wr(3'd7, 32'h3);

    // R9: chain order
    wr(3'd6, 32'h7);
    xfer(1, 0, 2'b00, 16'h4000, 16'h0);
    chk("R9 unit1 alone halt", halt_req, 0);
    chk("R9 unit1 alone armed", chain_armed, 0);
    xfer(1, 0, 2'b01, 16'h1234, 16'hBEEF);
    chk("R9 unit0 no halt", halt_req, 0);
    chk("R9 unit0 arms", chain_armed, 1);
    chk("R9 unit0 no stat", stat_hit, 0);
    xfer(1, 0, 2'b00, 16'h4000, 16'h0);
    chk("R9 chained halt", halt_req, 1);
    chk("R9 chained stat", stat_hit, 2'b10);
    chk("R10 armed cleared on halt", chain_armed, 0);
    wr(3'd7, 32'h3);
    // unit 1 now matches every data access
    wr(3'd3, 32'hFFFF_4000);
    xfer(1, 0, 2'b01, 16'h1234, 16'hBEEF);
    chk("R9 both same cycle no halt", halt_req, 0);
    chk("R9 both same cycle arms", chain_armed, 1);
    xfer(1, 0, 2'b01, 16'h1234, 16'hBEEF);
    chk("R9 second both halts", halt_req, 1);
    chk("R10 halt beats rearm", chain_armed, 0);
    wr(3'd7, 32'h3);

    // R10: leaving chain mode clears the arm
    wr(3'd3, 32'h0000_4000);
    xfer(1, 0, 2'b01, 16'h1234, 16'hBEEF);
    chk("R10 armed again", chain_armed, 1);
    wr(3'd6, 32'h0);
    xfer(0, 0, 2'b00, 16'h0, 16'h0);
    chk("R10 chain off clears", chain_armed, 0);
    wr(3'd6, 32'h7);
    xfer(1, 0, 2'b00, 16'h4000, 16'h0);
    chk("R10 no stale arm halt", halt_req, 0);
    chk("R10 no stale arm stat", stat_hit, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule